// File: doc/BRIEF.md
# Bus-Borrowing Block Transfer Engine

This block moves a programmed run of words between an I/O data port and memory without the processor doing the copying. Software sets a start address and a word count, then writes a control word that picks the direction, picks an ownership policy and launches the run. The engine then asks the processor for the memory bus. It waits until the processor has finished its current operation, floated its own address and data lines and answered with a grant. Only then does it drive memory, one word per granted cycle.

Two ownership policies are offered. In burst mode the bus is held from the first word to the last. In cycle-steal mode the engine hands the bus back after every word, waits for the grant to go away and asks again. This lets the processor run between words. When the last word has moved, the request is withdrawn and a sticky interrupt flag is raised. Software clears the flag with a dedicated write.

Top module: `dma_bus_master`

## Requirements
- R1: After synchronous reset, bus_req, bus_oe, irq, every memory and I/O strobe, and mem_addr are all 0.
- R2: Register select 0 loads the start address and select 1 loads the word count (low CNT_W bits). Writing select 2 with bit 2 set starts a run, with bit 0 as direction (0 port-to-memory, 1 memory-to-port) and bit 1 as policy (0 burst, 1 cycle-steal). If the count is not zero, bus_req is high in the cycle after that write.
- R3: bus_oe, mem_we, mem_re, io_rd and io_wr are high only in cycles where the engine is transferring and bus_grant is high. mem_we and mem_re are never high together.
- R4: Each transferred word uses the current address, which then increments by one while the remaining count drops by one. Port-to-memory words take io_rdata into mem_wdata with mem_we and io_rd. Memory-to-port words take mem_rdata into io_wdata with mem_re and io_wr.
- R5: In burst mode bus_req stays high from the request until the last word, so a run makes exactly one request.
- R6: In cycle-steal mode bus_req falls in the cycle after every word and is raised again for the next word, so a run of N words makes N requests.
- R7: After withdrawing bus_req, the engine does not raise it again until bus_grant has been seen low.
- R8: In the cycle after the last word, bus_req is low and irq is high. irq stays high until a write to register select 3 clears it.
- R9: While a run is in progress, writes to selects 0, 1 and 2 are ignored, including a second start.
- R10: A start with a word count of zero raises irq in the next cycle and never raises bus_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 address, 1 count, 2 control/start, 3 clear interrupt) |
| cfg_wdata | input | ADDR_W | Register write data |
| irq | output | 1 | Sticky completion interrupt |
| bus_req | output | 1 | Request for memory bus ownership |
| bus_grant | input | 1 | Processor grant; its buses are floated while high |
| bus_oe | output | 1 | Enable for the engine's bus drivers |
| mem_addr | output | ADDR_W | Memory address, zero when not driving |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid in the same cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| io_rdata | input | DATA_W | Word offered by the I/O port |
| io_rd | output | 1 | I/O port word consumed |
| io_wdata | output | DATA_W | Word delivered to the I/O port |
| io_wr | output | 1 | I/O port write strobe |

## Verification
The assertions check these properties on every cycle: drivers and strobes appear only under grant, the address steps once per word, and a new request never rises while grant is still high. They also check that burst holds the request between words while cycle-steal drops it after each one, and that the completion flag rises after the last word and then holds. Other properties can only be shown by the bench scenarios with a delaying processor model: the data that actually lands in memory or at the port, the number of requests per run, that configuration writes during a run leave no trace, and that a zero-length start completes without ever touching the bus.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_REQ     = 2'd1,
        ST_MOVE    = 2'd2,
        ST_RELEASE = 2'd3
    } dma_state_e;

    typedef enum logic {
        DIR_PORT_TO_MEM = 1'b0,
        DIR_MEM_TO_PORT = 1'b1
    } dma_dir_e;

    typedef enum logic {
        OWN_BURST = 1'b0,
        OWN_STEAL = 1'b1
    } dma_own_e;

    typedef struct packed {
        dma_dir_e dir;
        dma_own_e own;
    } dma_mode_t;

    localparam logic [1:0] SEL_ADDR  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;
    localparam logic [1:0] SEL_CLEAR = 2'd3;

    localparam int CTRL_DIR_BIT   = 0;
    localparam int CTRL_STEAL_BIT = 1;
    localparam int CTRL_GO_BIT    = 2;

    function automatic logic holds_request(dma_state_e s);
        return (s == ST_REQ) || (s == ST_MOVE);
    endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              busy,
    input  logic              done,
    output logic [ADDR_W-1:0] start_addr,
    output logic [CNT_W-1:0]  start_count,
    output dma_mode_t         mode_in,
    output logic              start,
    output logic              irq
);

    logic clear_hit;

    assign clear_hit = cfg_we && (cfg_sel == SEL_CLEAR);
    assign start     = cfg_we && (cfg_sel == SEL_CTRL) && cfg_wdata[CTRL_GO_BIT] && !busy;

    always_comb begin
        mode_in.dir = dma_dir_e'(cfg_wdata[CTRL_DIR_BIT]);
        mode_in.own = dma_own_e'(cfg_wdata[CTRL_STEAL_BIT]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_addr  <= '0;
            start_count <= '0;
        end else if (cfg_we && !busy) begin
            case (cfg_sel)
                SEL_ADDR:  start_addr  <= cfg_wdata;
                SEL_COUNT: start_count <= cfg_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else if (done) begin
            irq <= 1'b1;
        end else if (clear_hit) begin
            irq <= 1'b0;
        end
    end

    // R8: completion always lands in the flag
    p_irq_set_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> irq);

    // R8: flag is sticky until cleared
    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (irq && !clear_hit) |=> irq);

    // R9: configuration frozen during a run
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(start_addr) && $stable(start_count)));

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_count,
    input  dma_mode_t         mode_in,
    input  logic              bus_grant,
    output logic              bus_req,
    output logic              move,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] cur_addr,
    output dma_mode_t         mode
);

    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    dma_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;
    dma_mode_t         mode_q;
    logic              last_word;
    logic              zero_start;
    logic              launch;

    assign last_word  = (left_q == CNT_ONE);
    assign zero_start = (state_q == ST_IDLE) && start && (start_count == '0);
    assign launch     = (state_q == ST_IDLE) && start && (start_count != '0);
    assign move       = (state_q == ST_MOVE) && bus_grant;
    assign done       = zero_start || (move && last_word);
    assign bus_req    = holds_request(state_q);
    assign busy       = (state_q != ST_IDLE);
    assign cur_addr   = addr_q;
    assign mode       = mode_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (launch) state_d = ST_REQ;
            ST_REQ:     if (bus_grant) state_d = ST_MOVE;
            ST_MOVE:    if (move && (last_word || mode_q.own == OWN_STEAL)) state_d = ST_RELEASE;
            ST_RELEASE: if (!bus_grant) state_d = (left_q == '0) ? ST_IDLE : ST_REQ;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            left_q  <= '0;
            mode_q  <= '0;
        end else begin
            state_q <= state_d;
            if (launch) begin
                addr_q <= start_addr;
                left_q <= start_count;
                mode_q <= mode_in;
            end else if (move) begin
                addr_q <= addr_q + ADDR_ONE;
                left_q <= left_q - CNT_ONE;
            end
        end
    end

    // R7: a fresh request never overlaps a grant still held
    p_req_after_release_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> !bus_grant);

    // R5: burst keeps ownership between words
    p_burst_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (move && !last_word && mode_q.own == OWN_BURST) |=> bus_req);

    // R6: cycle-steal returns the bus after each word
    p_steal_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (move && mode_q.own == OWN_STEAL) |=> !bus_req);

    // R8: request withdrawn after the final word
    p_last_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (move && last_word) |=> !bus_req);

    // R4: address advances by exactly one per word
    p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
        move |=> (cur_addr == ADDR_W'($past(cur_addr) + ADDR_ONE)));

    // R10: empty run never asks for the bus
    p_zero_no_req_r10: assert property (@(posedge clk) disable iff (rst)
        zero_start |=> !bus_req);

endmodule

// File: rtl/dma_bus_port.sv
module dma_bus_port
    import dma_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter bit PARK_ZERO = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              move,
    input  dma_dir_e          dir,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] io_rdata,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic              io_rd,
    output logic [DATA_W-1:0] io_wdata,
    output logic              io_wr
);

    logic to_mem;
    logic to_port;

    assign to_mem  = move && (dir == DIR_PORT_TO_MEM);
    assign to_port = move && (dir == DIR_MEM_TO_PORT);

    assign bus_oe = move;
    assign mem_we = to_mem;
    assign io_rd  = to_mem;
    assign mem_re = to_port;
    assign io_wr  = to_port;

    generate
        if (PARK_ZERO) begin : g_park_zero
            assign mem_addr  = move    ? cur_addr  : '0;
            assign mem_wdata = to_mem  ? io_rdata  : '0;
            assign io_wdata  = to_port ? mem_rdata : '0;
        end else begin : g_park_pass
            assign mem_addr  = cur_addr;
            assign mem_wdata = io_rdata;
            assign io_wdata  = mem_rdata;
        end
    endgenerate

    // R3: no strobe without the driver enable
    p_strobe_needs_oe_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re || io_rd || io_wr) |-> bus_oe);

    // R3: read and write strobes exclusive
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we, mem_re}));

endmodule

// File: rtl/dma_bus_master.sv
module dma_bus_master
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              irq,
    output logic              bus_req,
    input  logic              bus_grant,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] io_rdata,
    output logic              io_rd,
    output logic [DATA_W-1:0] io_wdata,
    output logic              io_wr
);

    logic [ADDR_W-1:0] start_addr;
    logic [CNT_W-1:0]  start_count;
    dma_mode_t         mode_in;
    dma_mode_t         mode_run;
    logic              start;
    logic              busy;
    logic              done;
    logic              move;
    logic [ADDR_W-1:0] cur_addr;

    dma_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .busy       (busy),
        .done       (done),
        .start_addr (start_addr),
        .start_count(start_count),
        .mode_in    (mode_in),
        .start      (start),
        .irq        (irq)
    );

    dma_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_addr (start_addr),
        .start_count(start_count),
        .mode_in    (mode_in),
        .bus_grant  (bus_grant),
        .bus_req    (bus_req),
        .move       (move),
        .busy       (busy),
        .done       (done),
        .cur_addr   (cur_addr),
        .mode       (mode_run)
    );

    dma_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PARK_ZERO(1'b1)) u_port (
        .clk      (clk),
        .rst      (rst),
        .move     (move),
        .dir      (mode_run.dir),
        .cur_addr (cur_addr),
        .mem_rdata(mem_rdata),
        .io_rdata (io_rdata),
        .bus_oe   (bus_oe),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_we   (mem_we),
        .mem_re   (mem_re),
        .io_rd    (io_rd),
        .io_wdata (io_wdata),
        .io_wr    (io_wr)
    );

    // R3: drivers enabled only under grant
    p_drive_needs_grant_r3: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> bus_grant);

endmodule

// File: tb/test_dma_bus_master.sv
module test_dma_bus_master;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [1:0]    cfg_sel;
    logic [AW-1:0] cfg_wdata;
    logic          irq, bus_req, bus_grant, bus_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata, io_rdata, io_wdata;
    logic          mem_we, mem_re, io_rd, io_wr;

    always #10 clk = ~clk;

    dma_bus_master #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_dma_bus_master (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .irq(irq), .bus_req(bus_req), .bus_grant(bus_grant), .bus_oe(bus_oe),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_re(mem_re), .io_rdata(io_rdata), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_wr(io_wr)
    );

    // memory and I/O environment
    logic [DW-1:0] mem [0:255];
    logic [15:0]   io_serial;
    logic [DW-1:0] sink_q[$];
    assign mem_rdata = mem[mem_addr[7:0]];
    assign io_rdata  = 16'h5000 + io_serial;

    int checks = 0;
    int fails  = 0;
    int req_rises = 0;
    logic prev_req = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int            m_phase;   // 0 idle, 1 asking, 2 owning, 3 handing back
    logic [AW-1:0] m_saddr, m_addr;
    logic [CW-1:0] m_count, m_left;
    bit            m_dir, m_steal, m_irq, m_set;

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_saddr = '0; m_addr = '0; m_count = '0; m_left = '0;
            m_dir = 0; m_steal = 0; m_irq = 0;
        end else begin
            m_set = 0;
            case (m_phase)
                0: if (cfg_we) begin
                    if (cfg_sel == 2'd0) m_saddr = cfg_wdata;
                    if (cfg_sel == 2'd1) m_count = cfg_wdata[CW-1:0];
                    if (cfg_sel == 2'd2 && cfg_wdata[2]) begin
                        if (m_count == 0) m_set = 1;
                        else begin
                            m_addr = m_saddr; m_left = m_count;
                            m_dir = cfg_wdata[0]; m_steal = cfg_wdata[1];
                            m_phase = 1;
                        end
                    end
                end
                1: if (bus_grant) m_phase = 2;
                2: if (bus_grant) begin
                    m_addr = m_addr + 1'b1;
                    m_left = m_left - 1'b1;
                    if (m_left == 0) begin m_set = 1; m_phase = 3; end
                    else if (m_steal) m_phase = 3;
                end
                default: if (!bus_grant) m_phase = (m_left == 0) ? 0 : 1;
            endcase
            if (m_set) m_irq = 1;
            else if (cfg_we && cfg_sel == 2'd3) m_irq = 0;
        end
    end

    // per-cycle comparison and environment update, away from the clock edge
    always @(negedge clk) begin
        if (!rst) begin
            automatic bit mv = (m_phase == 2) && bus_grant;
            automatic bit ereq = (m_phase == 1) || (m_phase == 2);
            automatic logic [4:0] es = {mv, mv && !m_dir, mv && m_dir, mv && !m_dir, mv && m_dir};
            chk(bus_req === ereq, "R5/R6 bus_req", bus_req, ereq);
            chk({bus_oe, mem_we, mem_re, io_rd, io_wr} === es, "R3 strobes",
                {bus_oe, mem_we, mem_re, io_rd, io_wr}, es);
            chk(mem_addr === (mv ? m_addr : '0), "R4 mem_addr", mem_addr, mv ? m_addr : '0);
            chk(irq === m_irq, "R8 irq", irq, m_irq);
            if (bus_req && !prev_req) begin
                req_rises++;
                chk(!bus_grant, "R7 request while grant high", bus_grant, 0);
            end
            if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
            if (io_rd) io_serial = io_serial + 1'b1;
            if (io_wr) sink_q.push_back(io_wdata);
        end
        prev_req = bus_req;
    end

    // processor model: finish current work, then grant; release after a hold
    int cpu_delay = 2;
    int cpu_hold  = 0;
    initial begin
        automatic int wcnt = 0;
        automatic int hcnt = 0;
        bus_grant = 1'b0;
        forever begin
            @(posedge clk); #2;
            if (rst) begin
                bus_grant = 1'b0; wcnt = 0; hcnt = 0;
            end else if (bus_req && !bus_grant) begin
                if (wcnt >= cpu_delay) begin bus_grant = 1'b1; wcnt = 0; end
                else wcnt++;
            end else if (!bus_req && bus_grant) begin
                if (hcnt >= cpu_hold) begin bus_grant = 1'b0; hcnt = 0; end
                else hcnt++;
            end
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] d);
        @(posedge clk); #2;
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk); #2;
        cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
    endtask

    task automatic wait_done(input string tag);
        automatic int n = 0;
        while (!(irq === 1'b1 && !bus_req && !bus_grant) && n < 3000) begin
            @(negedge clk); n++;
        end
        chk(n < 3000, tag, n, 3000);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        automatic logic [15:0] s0;
        for (int i = 0; i < 256; i++) mem[i] = 16'hDEAD;
        for (int i = 0; i < 8; i++) mem[8'h40 + i] = 16'hC000 + 16'(i);
        io_serial = '0;
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({bus_req, bus_oe, irq, mem_we, mem_re, io_rd, io_wr} === 7'b0, "R1 reset outputs",
            {bus_req, bus_oe, irq, mem_we, mem_re, io_rd, io_wr}, 0);
        chk(mem_addr === '0, "R1 reset mem_addr", mem_addr, 0);
        @(posedge clk); #2; rst = 1'b0;

        // burst, port to memory, 5 words at 0x10
        cpu_delay = 2; cpu_hold = 0;
        cfg_write(2'd0, 16'h0010);
        cfg_write(2'd1, 16'd5);
        s0 = io_serial; req_rises = 0;
        cfg_write(2'd2, 16'b100);
        @(negedge clk);
        chk(bus_req === 1'b1, "R2 request after start", bus_req, 1);
        wait_done("R8 burst run finished");
        for (int i = 0; i < 5; i++)
            chk(mem[8'h10 + i] === 16'h5000 + s0 + 16'(i), "R4 burst data", mem[8'h10 + i], 16'h5000 + s0 + 16'(i));
        chk(mem[8'h15] === 16'hDEAD, "R4 word past block untouched", mem[8'h15], 16'hDEAD);
        chk(req_rises == 1, "R5 single request for burst", req_rises, 1);
        repeat (4) @(negedge clk);
        chk(irq === 1'b1, "R8 irq sticky", irq, 1);
        cfg_write(2'd3, 16'h0);
        @(negedge clk);
        chk(irq === 1'b0, "R8 irq cleared", irq, 0);

        // cycle-steal, memory to port, 4 words at 0x40, slow grant release
        cpu_delay = 1; cpu_hold = 2;
        sink_q.delete();
        cfg_write(2'd0, 16'h0040);
        cfg_write(2'd1, 16'd4);
        req_rises = 0;
        cfg_write(2'd2, 16'b111);
        wait_done("R8 steal run finished");
        chk(sink_q.size() == 4, "R6 words delivered", sink_q.size(), 4);
        for (int i = 0; i < 4 && i < sink_q.size(); i++)
            chk(sink_q[i] === 16'hC000 + 16'(i), "R4 port data", sink_q[i], 16'hC000 + 16'(i));
        chk(req_rises == 4, "R6 request per word", req_rises, 4);
        cfg_write(2'd3, 16'h0);

        // writes during a run are ignored, 6 words at 0x20
        cpu_delay = 3; cpu_hold = 1;
        cfg_write(2'd0, 16'h0020);
        cfg_write(2'd1, 16'd6);
        s0 = io_serial;
        cfg_write(2'd2, 16'b100);
        cfg_write(2'd0, 16'h0080);
        cfg_write(2'd1, 16'd2);
        cfg_write(2'd2, 16'b110);
        wait_done("R9 busy run finished");
        chk(io_serial - s0 == 6, "R9 word count kept", io_serial - s0, 6);
        chk(mem[8'h80] === 16'hDEAD, "R9 late address ignored", mem[8'h80], 16'hDEAD);
        cfg_write(2'd3, 16'h0);
        s0 = io_serial;
        cfg_write(2'd2, 16'b100);
        wait_done("R9 rerun finished");
        chk(mem[8'h25] === 16'h5000 + s0 + 16'd5, "R9 original range reused", mem[8'h25], 16'h5000 + s0 + 16'd5);
        cfg_write(2'd3, 16'h0);

        // zero-length start
        cfg_write(2'd1, 16'd0);
        req_rises = 0;
        cfg_write(2'd2, 16'b100);
        @(negedge clk);
        chk(irq === 1'b1, "R10 irq on empty run", irq, 1);
        chk(bus_req === 1'b0, "R10 no request", bus_req, 0);
        repeat (5) @(negedge clk);
        chk(req_rises == 0, "R10 bus never requested", req_rises, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule